// File: doc/BRIEF.md
# Flash Mirror Address Decoder

This block translates byte addresses on a 20-bit microcontroller bus. A programmable window in data space is redirected onto program flash, so constant tables stored in flash can be read with ordinary data loads. Each request carries a byte address, an access kind (data read, data write or instruction fetch) and a bank-select bit from a processor-mode control register. One cycle later the block presents the physical address, a flag that says the window was hit, a stall request for mirrored data reads, and a filler indication for accesses that have nothing behind them.

Instruction fetches are never redirected through the window. A fetch beyond the end of populated flash but below the special-function area is answered with a filler byte. A data read in the special-function area that no peripheral claims is also answered with a filler byte. The window start, its flash target, its length and the end of populated flash are all plain inputs that come from configuration registers elsewhere.

Top module: `flash_mirror_decoder`

## Requirements
- R1: Bits of `i_addr` above bit 19 have no effect on any output; decoding uses only the low 20 bits.
- R2: A data read (`i_kind`=2'b00) or data write (`i_kind`=2'b01) whose address A satisfies `i_win_base` <= A < `i_win_base`+`i_win_len` gives `o_addr` = A - `i_win_base` + `i_flash_base` (modulo 2^20) and `o_mirror`=1.
- R3: When `i_bank_hi` is 1, bit 16 of a translated address is forced to 1; addresses that are not translated are not altered by `i_bank_hi`.
- R4: A data access outside the window passes its masked address to `o_addr` unchanged with `o_mirror`=0.
- R5: An instruction fetch (`i_kind`=2'b10 or 2'b11) is never translated: `o_addr` is the masked address and `o_mirror`=0.
- R6: A fetch with `i_rom_limit` <= A < 0xF0000 sets `o_fill`=1 and `o_fill_data`=0xFF; other fetches set `o_fill`=0.
- R7: A data read with 0xF0000 <= A <= 0xF0FFF that is outside the window and has `i_periph_claim`=0 sets `o_fill`=1 and `o_fill_data`=0x11; a claimed read or any write sets `o_fill`=0.
- R8: A mirrored data read raises `o_stall` in the cycle its result is valid and holds it for exactly 3 cycles; a mirrored write, or a read outside the window, causes no stall.
- R9: All outputs are registered: a request with `i_valid`=1 appears on the outputs with `o_valid`=1 one clock later; with `i_valid`=0 the next cycle has `o_valid`=0. Reset clears `o_valid`, `o_mirror`, `o_fill` and `o_stall`.
- R10: The window includes its first address and excludes the address `i_win_base`+`i_win_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_valid | input | 1 | Request present this cycle |
| i_addr | input | IN_W (24) | Byte address from the bus, upper bits ignored |
| i_kind | input | 2 | 00 data read, 01 data write, 1x instruction fetch |
| i_bank_hi | input | 1 | Mode bit that selects the upper 64K flash bank for translated addresses |
| i_win_base | input | 20 | First data-space address of the window |
| i_flash_base | input | 20 | Flash address that the window start maps to |
| i_win_len | input | 20 | Window length in bytes |
| i_rom_limit | input | 20 | First address above populated flash |
| i_periph_claim | input | 1 | A peripheral decodes this special-function address |
| o_valid | output | 1 | Result valid |
| o_addr | output | 20 | Physical address |
| o_mirror | output | 1 | Access hit the window |
| o_fill | output | 1 | Respond with filler data instead of memory |
| o_fill_data | output | 8 | Filler byte (0xFF or 0x11) |
| o_stall | output | 1 | Wait-state request for a mirrored data read |

## Verification
The bench builds the block with a 24-bit address input, four bits wider than the decoded bus, so that junk in the high bits can be driven and shown to leave every result untouched. The stall length stays at its default of 3 so each wait cycle can be sampled one by one. The window inputs start at a 0x7000-byte window at 0xF1000 mapped to flash 0x01000 and are then moved to a 0x100-byte window at 0xE0000, which puts both window edges and a second translation offset within reach; the end of flash is set to 0x40000 so the fetch filler range has two reachable edges.

// File: rtl/mirror_pkg.sv
// Shared definitions for the flash mirror decoder.
// Assumes a byte-addressed bus; access kinds are a 2-bit code.
package mirror_pkg;

    // Access kind codes carried on i_kind; bit 1 set means instruction fetch.
    typedef enum logic [1:0] {
        KIND_READ      = 2'b00,
        KIND_WRITE     = 2'b01,
        KIND_FETCH     = 2'b10,
        KIND_FETCH_ALT = 2'b11
    } acc_kind_e;

    // Filler returned for fetches beyond populated flash.
    localparam logic [7:0] FILL_FETCH = 8'hFF;
    // Filler returned for unclaimed special-function reads.
    localparam logic [7:0] FILL_SFR   = 8'h11;

    // Per-access classification produced before the output register.
    typedef struct packed {
        logic       fill;
        logic [7:0] fill_data;
        logic       stall_req;
    } acc_class_t;

    // True when the kind code denotes an instruction fetch.
    function automatic logic is_fetch(input logic [1:0] kind);
        return kind[1];
    endfunction

    // True when the kind code denotes a data read.
    function automatic logic is_read(input logic [1:0] kind);
        return kind == KIND_READ;
    endfunction

endpackage

// File: rtl/mirror_window.sv
// Window match and address translation.
// Decides whether a masked address lies inside [base, base+len) and forms
// the flash address for it. Assumes base+len may exceed the address space;
// the comparison is done one bit wider so it never wraps.
module mirror_window #(
    parameter int AW   = 20,
    parameter int BANK = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] win_base,
    input  logic [AW-1:0] flash_base,
    input  logic [AW-1:0] win_len,
    input  logic          bank_hi,
    output logic          hit,
    output logic [AW-1:0] phys
);

    logic [AW:0]   win_end;
    logic          above_base;
    logic          below_end;
    logic [AW-1:0] offset;
    logic [AW-1:0] moved;

    // Extended-width end of the window so that a window touching the top does not wrap.
    always_comb win_end = {1'b0, win_base} + {1'b0, win_len};

    // Bound comparisons for the half-open window.
    always_comb begin
        above_base = addr >= win_base;
        below_end  = {1'b0, addr} < win_end;
        hit        = above_base && below_end;
    end

    // Offset into the window and relocated flash address, modulo the bus width.
    always_comb begin
        offset = addr - win_base;
        moved  = flash_base + offset;
    end

    // Bank select forces the chosen bit of the relocated address.
    always_comb begin
        phys = moved;
        if (bank_hi) phys[BANK] = 1'b1;
    end

endmodule

// File: rtl/mirror_class.sv
// Access classification: filler responses and stall request.
// Assumes the window hit has already been computed for the same address.
// Fetches take the filler only in the hole between the end of flash and the
// special-function area; data reads take it only in the special-function
// area when no peripheral claims the address and the window was missed.
module mirror_class
    import mirror_pkg::*;
#(
    parameter int            AW     = 20,
    parameter logic [AW-1:0] SFR_LO = 20'hF0000,
    parameter logic [AW-1:0] SFR_HI = 20'hF0FFF
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    kind,
    input  logic [AW-1:0] rom_limit,
    input  logic          periph_claim,
    input  logic          win_hit,
    output acc_class_t    cls
);

    logic in_hole;
    logic in_sfr;

    // Range tests for the unpopulated flash hole and the special-function area.
    always_comb begin
        in_hole = (addr >= rom_limit) && (addr < SFR_LO);
        in_sfr  = (addr >= SFR_LO) && (addr <= SFR_HI);
    end

    // Filler selection and stall request by access kind.
    always_comb begin
        cls = '0;
        if (is_fetch(kind)) begin
            if (in_hole) begin
                cls.fill      = 1'b1;
                cls.fill_data = FILL_FETCH;
            end
        end else if (is_read(kind)) begin
            if (win_hit) begin
                cls.stall_req = 1'b1;
            end else if (in_sfr && !periph_claim) begin
                cls.fill      = 1'b1;
                cls.fill_data = FILL_SFR;
            end
        end
    end

endmodule

// File: rtl/mirror_wait.sv
// Wait-state counter for mirrored reads.
// A load starts a run of WAIT_CYC stall cycles beginning in the cycle after
// the load edge. A load during a run restarts it. Synchronous active-low reset.
module mirror_wait #(
    parameter int WAIT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic stall
);

    localparam int CW = $clog2(WAIT_CYC + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(WAIT_CYC);

    logic [CW-1:0] remain;

    // Count remaining stall cycles down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             remain <= '0;
        else if (load)          remain <= LOAD_VAL;
        else if (remain != '0)  remain <= remain - 1'b1;
    end

    // Stall while any cycles remain.
    always_comb stall = remain != '0;

endmodule

// File: rtl/flash_mirror_decoder.sv
// Flash mirror address decoder, top level.
// Masks the bus address to AW bits, redirects data accesses that fall in the
// programmable window onto flash, leaves fetches untranslated, flags filler
// responses, and registers every result one cycle after the request.
// Assumes the configuration inputs are stable while requests are issued and
// that the requester honours o_stall before issuing dependent reads.
module flash_mirror_decoder
    import mirror_pkg::*;
#(
    parameter int            IN_W     = 24,
    parameter int            AW       = 20,
    parameter int            BANK     = 16,
    parameter int            WAIT_CYC = 3,
    parameter logic [AW-1:0] SFR_LO   = 20'hF0000,
    parameter logic [AW-1:0] SFR_HI   = 20'hF0FFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            i_valid,
    input  logic [IN_W-1:0] i_addr,
    input  logic [1:0]      i_kind,
    input  logic            i_bank_hi,
    input  logic [AW-1:0]   i_win_base,
    input  logic [AW-1:0]   i_flash_base,
    input  logic [AW-1:0]   i_win_len,
    input  logic [AW-1:0]   i_rom_limit,
    input  logic            i_periph_claim,
    output logic            o_valid,
    output logic [AW-1:0]   o_addr,
    output logic            o_mirror,
    output logic            o_fill,
    output logic [7:0]      o_fill_data,
    output logic            o_stall
);

    logic [AW-1:0] a_masked;
    logic          win_hit;
    logic [AW-1:0] win_phys;
    logic          use_window;
    logic [AW-1:0] next_addr;
    acc_class_t    cls;

    // Masking of the bus address; a wider bus leaves its upper bits unread.
    generate
        if (IN_W > AW) begin : g_wide
            logic unused_hi;
            assign unused_hi = ^i_addr[IN_W-1:AW];
            assign a_masked  = i_addr[AW-1:0];
        end else begin : g_exact
            assign a_masked = AW'(i_addr);
        end
    endgenerate

    mirror_window #(.AW(AW), .BANK(BANK)) u_win (
        .addr       (a_masked),
        .win_base   (i_win_base),
        .flash_base (i_flash_base),
        .win_len    (i_win_len),
        .bank_hi    (i_bank_hi),
        .hit        (win_hit),
        .phys       (win_phys)
    );

    mirror_class #(.AW(AW), .SFR_LO(SFR_LO), .SFR_HI(SFR_HI)) u_cls (
        .addr         (a_masked),
        .kind         (i_kind),
        .rom_limit    (i_rom_limit),
        .periph_claim (i_periph_claim),
        .win_hit      (win_hit),
        .cls          (cls)
    );

    mirror_wait #(.WAIT_CYC(WAIT_CYC)) u_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (i_valid && cls.stall_req),
        .stall (o_stall)
    );

    // Pick the translated address only for data accesses inside the window.
    always_comb begin
        use_window = win_hit && !is_fetch(i_kind);
        next_addr  = use_window ? win_phys : a_masked;
    end

    // Output register for the address and flags of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid     <= 1'b0;
            o_addr      <= '0;
            o_mirror    <= 1'b0;
            o_fill      <= 1'b0;
            o_fill_data <= '0;
        end else begin
            o_valid <= i_valid;
            if (i_valid) begin
                o_addr      <= next_addr;
                o_mirror    <= use_window;
                o_fill      <= cls.fill;
                o_fill_data <= cls.fill_data;
            end else begin
                o_mirror <= 1'b0;
                o_fill   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mirror_decoder_chk.sv
// Assertion checker for the flash mirror decoder, bound to the top module.
// Relates the request ports to the registered outputs one cycle later.
module mirror_decoder_chk #(
    parameter int AW   = 20,
    parameter int BANK = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          i_valid,
    input logic [1:0]    i_kind,
    input logic          i_bank_hi,
    input logic          o_valid,
    input logic [AW-1:0] o_addr,
    input logic          o_mirror,
    input logic          o_fill,
    input logic          o_stall
);

    // R9: a request shows up as a valid result on the next cycle.
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        i_valid |=> o_valid);

    // R9: no request means no valid result on the next cycle.
    a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !i_valid |=> !o_valid && !o_mirror && !o_fill);

    // R5: fetches are never reported as mirrored.
    a_r5_fetch_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && i_kind[1]) |=> !o_mirror);

    // R3: a translated address under the bank bit has that bit set.
    a_r3_bank_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && i_bank_hi) |=> (!o_mirror || o_addr[BANK]));

    // R8: from an idle counter, a read stalls exactly when it was mirrored.
    a_r8_read_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && i_kind == 2'b00 && !o_stall) |=> (o_stall == o_mirror));

    // R8: from an idle counter, a write never starts a stall.
    a_r8_write_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && i_kind == 2'b01 && !o_stall) |=> !o_stall);

    // R7: a filler response is never a mirrored one.
    a_r7_fill_not_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        o_fill |-> !o_mirror);

endmodule

bind flash_mirror_decoder mirror_decoder_chk #(.AW(AW), .BANK(BANK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .i_valid   (i_valid),
    .i_kind    (i_kind),
    .i_bank_hi (i_bank_hi),
    .o_valid   (o_valid),
    .o_addr    (o_addr),
    .o_mirror  (o_mirror),
    .o_fill    (o_fill),
    .o_stall   (o_stall)
);

// File: tb/sim_flash_mirror_decoder.sv
`timescale 1ns/1ps
// Directed bench for the flash mirror decoder: one task per scenario.
module sim_flash_mirror_decoder;

    localparam int IN_W = 24;
    localparam int AW   = 20;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            i_valid;
    logic [IN_W-1:0] i_addr;
    logic [1:0]      i_kind;
    logic            i_bank_hi;
    logic [AW-1:0]   i_win_base;
    logic [AW-1:0]   i_flash_base;
    logic [AW-1:0]   i_win_len;
    logic [AW-1:0]   i_rom_limit;
    logic            i_periph_claim;
    logic            o_valid;
    logic [AW-1:0]   o_addr;
    logic            o_mirror;
    logic            o_fill;
    logic [7:0]      o_fill_data;
    logic            o_stall;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    flash_mirror_decoder #(.IN_W(IN_W), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_addr(i_addr),
        .i_kind(i_kind), .i_bank_hi(i_bank_hi), .i_win_base(i_win_base),
        .i_flash_base(i_flash_base), .i_win_len(i_win_len),
        .i_rom_limit(i_rom_limit), .i_periph_claim(i_periph_claim),
        .o_valid(o_valid), .o_addr(o_addr), .o_mirror(o_mirror),
        .o_fill(o_fill), .o_fill_data(o_fill_data), .o_stall(o_stall)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present one request, sample the registered result, then go idle.
    task automatic issue(input logic [IN_W-1:0] a, input logic [1:0] k);
        @(negedge clk);
        i_valid = 1'b1; i_addr = a; i_kind = k;
        @(posedge clk); #1;
        @(negedge clk);
        i_valid = 1'b0;
    endtask

    // Check the full result of the last request.
    task automatic expect_res(input string tag, input logic [AW-1:0] addr,
                              input logic mir, input logic fill, input logic [7:0] fd);
        chk({tag, " addr"}, o_addr, addr);
        chk({tag, " mirror"}, o_mirror, mir);
        chk({tag, " fill"}, o_fill, fill);
        if (fill) chk({tag, " fill_data"}, o_fill_data, fd);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; i_valid = 1'b0; i_addr = '0; i_kind = 2'b00;
        i_bank_hi = 1'b0; i_periph_claim = 1'b0;
        i_win_base = 20'hF1000; i_flash_base = 20'h01000; i_win_len = 20'h07000;
        i_rom_limit = 20'h40000;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset o_valid", o_valid, 0);
        chk("R9 reset o_stall", o_stall, 0);
        chk("R9 reset o_mirror", o_mirror, 0);
        chk("R9 reset o_fill", o_fill, 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_window_read();
        issue(24'h0F2345, 2'b00);
        chk("R9 valid after request", o_valid, 1);
        expect_res("R2 read mid window", 20'h02345, 1, 0, 0);
        issue(24'h0F1000, 2'b00);
        expect_res("R10 read first window byte", 20'h01000, 1, 0, 0);
        issue(24'h0F7FFF, 2'b00);
        expect_res("R10 read last window byte", 20'h07FFF, 1, 0, 0);
        issue(24'h0F8000, 2'b00);
        expect_res("R10 read one past window", 20'hF8000, 0, 0, 0);
        issue(24'h0F0FFF, 2'b01);
        expect_res("R4 write below window", 20'hF0FFF, 0, 0, 0);
        @(posedge clk); #1;
        chk("R9 idle o_valid", o_valid, 0);
    endtask

    task automatic t_bank();
        i_bank_hi = 1'b1;
        issue(24'h0F2345, 2'b00);
        expect_res("R3 bank forces bit16", 20'h12345, 1, 0, 0);
        issue(24'h003000, 2'b00);
        expect_res("R3 untranslated not altered", 20'h03000, 0, 0, 0);
        issue(24'h0F2345, 2'b10);
        expect_res("R3 fetch not altered", 20'hF2345, 0, 0, 0);
        i_bank_hi = 1'b0;
    endtask

    task automatic t_write();
        repeat (5) @(posedge clk);
        issue(24'h0F4000, 2'b01);
        expect_res("R2 write in window", 20'h04000, 1, 0, 0);
        chk("R8 mirrored write no stall", o_stall, 0);
        @(posedge clk); #1;
        chk("R8 mirrored write no stall later", o_stall, 0);
    endtask

    task automatic t_stall();
        repeat (5) @(posedge clk);
        issue(24'h0F3000, 2'b00);
        chk("R8 stall cycle 1", o_stall, 1);
        @(posedge clk); #1; chk("R8 stall cycle 2", o_stall, 1);
        @(posedge clk); #1; chk("R8 stall cycle 3", o_stall, 1);
        @(posedge clk); #1; chk("R8 stall ends after 3", o_stall, 0);
        issue(24'h0F9000, 2'b00);
        chk("R8 read outside window no stall", o_stall, 0);
    endtask

    task automatic t_fetch();
        issue(24'h0F2345, 2'b10);
        expect_res("R5 fetch in window bypass", 20'hF2345, 0, 0, 0);
        issue(24'h0F2345, 2'b11);
        expect_res("R5 alt fetch code bypass", 20'hF2345, 0, 0, 0);
        issue(24'h040000, 2'b10);
        expect_res("R6 fetch at rom limit", 20'h40000, 0, 1, 8'hFF);
        issue(24'h0EFFFF, 2'b10);
        expect_res("R6 fetch below sfr", 20'hEFFFF, 0, 1, 8'hFF);
        issue(24'h03FFFF, 2'b10);
        expect_res("R6 fetch below limit", 20'h3FFFF, 0, 0, 0);
        issue(24'h0F0000, 2'b10);
        expect_res("R6 fetch in sfr area", 20'hF0000, 0, 0, 0);
        issue(24'h050000, 2'b00);
        expect_res("R6 data read in hole", 20'h50000, 0, 0, 0);
    endtask

    task automatic t_sfr();
        issue(24'h0F0010, 2'b00);
        expect_res("R7 unclaimed sfr read", 20'hF0010, 0, 1, 8'h11);
        issue(24'h0F0FFF, 2'b00);
        expect_res("R7 last sfr byte", 20'hF0FFF, 0, 1, 8'h11);
        i_periph_claim = 1'b1;
        issue(24'h0F0010, 2'b00);
        expect_res("R7 claimed sfr read", 20'hF0010, 0, 0, 0);
        i_periph_claim = 1'b0;
        issue(24'h0F0010, 2'b01);
        expect_res("R7 sfr write no fill", 20'hF0010, 0, 0, 0);
    endtask

    task automatic t_mask();
        issue(24'hAF2345, 2'b00);
        expect_res("R1 high bits ignored read", 20'h02345, 1, 0, 0);
        issue(24'h5F0010, 2'b00);
        expect_res("R1 high bits ignored sfr", 20'hF0010, 0, 1, 8'h11);
    endtask

    task automatic t_reprogram();
        i_win_base = 20'hE0000; i_flash_base = 20'h20000; i_win_len = 20'h00100;
        issue(24'h0E0080, 2'b00);
        expect_res("R2 moved window", 20'h20080, 1, 0, 0);
        issue(24'h0E00FF, 2'b01);
        expect_res("R10 moved window last byte", 20'h200FF, 1, 0, 0);
        issue(24'h0E0100, 2'b00);
        expect_res("R10 moved window end excluded", 20'hE0100, 0, 0, 0);
        issue(24'h0F2345, 2'b00);
        expect_res("R4 old window released", 20'hF2345, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_window_read();
        t_bank();
        t_write();
        t_stall();
        t_fetch();
        t_sfr();
        t_mask();
        t_reprogram();
        repeat (4) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule